// File: doc/BRIEF.md
# Codec Mixer Control Register File

This block is the host-visible control store for the output mixer of an audio codec. A host reads and writes 16-bit words at 7-bit addresses through a strobe interface: one write strobe, one read strobe, and a read word that is registered one cycle after the read strobe. Four words exist. One is a read-only identification word. One is the master output volume word, with left and right attenuation and mute. One is a configuration word whose bit 0 enables separate muting of the two channels. One is a serial-link setup word that the block only stores.

The block also drives the mixer datapath directly. It gives a 5-bit attenuation code for each channel (0 is 0 dB, 31 is 46.5 dB, 1.5 dB per step) and a mute line for each channel. With split muting off, the master mute silences both channels. With split muting on, it silences only the left channel, and a separate right-mute bit controls the right channel. Writing any value to the identification word is a software reset. It returns the volume and configuration words to their defaults and leaves the serial-link word as it was.

Top module: `codec_mix_regs`

## Requirements
- R1: When `rst` is high at a clock edge, the block loads every default. The volume word becomes 8000h, the configuration word 0000h and the serial word 0000h. `rd_data` becomes 0000h, both mute outputs go high and both attenuation outputs go to 0.
- R2: A write of any data to address 00h sets the volume word to 8000h and the configuration word to 0000h at that clock edge.
- R3: A read of address 00h returns 0090h. Bits 9:0 are the capability code, with bits 4 and 7 set. Bits 14:10 are the enhancement code, all zeros. Bit 15 reads 0. Writes never change this value.
- R4: Address 74h holds all 16 written bits and reads them back. Its default is 0000h, and a write to 00h leaves it unchanged.
- R5: The volume word at 02h has this layout:
  - bit 15: master mute
  - bits 12:8: left attenuation
  - bit 7: right mute
  - bits 4:0: right attenuation
  
  Bits 14, 13, 6 and 5 always read 0.
- R6: A write to 02h with bit 13 set stores 11111b as the left attenuation, whatever bits 12:8 hold. A write with bit 5 set stores 11111b as the right attenuation in the same way.
- R7: While split muting is off, a write to 02h stores 0 as the right-mute bit, whatever bit 7 holds. Turning split muting off also clears the stored right-mute bit.
- R8: With split muting off, `mute_left` and `mute_right` both equal the master mute bit. With split muting on, `mute_left` follows the master mute bit and `mute_right` follows the right-mute bit.
- R9: Bit 0 of the word at 76h is the split-mute enable. Bits 15:1 of that word read 0.
- R10: Any address other than 00h, 02h, 74h and 76h reads 0000h. Writes to such an address change no register and no output.
- R11: `rd_data` takes the addressed word at the clock edge where `rd_en` is high, and holds its value while `rd_en` is low. If a read and a write happen in the same cycle, the read returns the contents from before the write.
- R12: `att_left` and `att_right` show the stored left and right attenuation fields from the edge that writes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| att_left | output | 5 | Left attenuation code |
| att_right | output | 5 | Right attenuation code |
| mute_left | output | 1 | Left channel mute |
| mute_right | output | 1 | Right channel mute |

## Verification
The bench targets the interactions between words.

- A right-mute write issued while split muting is off must be dropped. A design that stores it would unmute or mute the right channel later, when split muting turns on.
- A software reset must spare the serial word. A design that clears it loses the link setup.
- Overflow bits 13 and 5 must saturate the attenuation to 31 and then read back as 0. A design that gets this wrong passes a quiet 6-bit level through as loud, or echoes reserved bits.
- A read and a write to the same word in one cycle must return the old contents. Undefined addresses must stay inert.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ATT_W  = 5;
  localparam int unsigned NCH    = 2;

  // bit positions inside the master volume word
  localparam int unsigned MV_MUTE_ALL = 15;
  localparam int unsigned MV_LEFT_LSB = 8;
  localparam int unsigned MV_MUTE_R   = 7;
  localparam int unsigned MV_RIGHT_LSB = 0;

  typedef struct packed {
    logic             mute_all;
    logic [ATT_W-1:0] left;
    logic             mute_r;
    logic [ATT_W-1:0] right;
  } mvol_t;

  localparam mvol_t MVOL_DEFAULT = '{mute_all: 1'b1, left: '0, mute_r: 1'b0, right: '0};

  function automatic logic [WORD_W-1:0] mvol_word(input mvol_t v);
    logic [WORD_W-1:0] w;
    w = '0;
    w[MV_MUTE_ALL] = v.mute_all;
    w[MV_LEFT_LSB +: ATT_W] = v.left;
    w[MV_MUTE_R] = v.mute_r;
    w[MV_RIGHT_LSB +: ATT_W] = v.right;
    return w;
  endfunction
endpackage

// File: rtl/cmx_vol_field.sv
module cmx_vol_field #(
  parameter int unsigned ATT_W = 5
) (
  input  logic [ATT_W:0]   raw,
  output logic [ATT_W-1:0] att
);
  // the top bit is a 6-bit overflow flag: saturate to full attenuation
  always_comb begin
    if (raw[ATT_W]) att = '1;
    else            att = raw[ATT_W-1:0];
  end
endmodule

// File: rtl/cmx_mute_route.sv
module cmx_mute_route (
  input  logic split,
  input  logic mute_all,
  input  logic mute_r,
  output logic mute_l_o,
  output logic mute_r_o
);
  always_comb begin
    mute_l_o = mute_all;
    mute_r_o = split ? mute_r : mute_all;
  end
endmodule

// File: rtl/cmx_read_mux.sv
module cmx_read_mux
  import cmx_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter logic [WORD_W-1:0] ID_VALUE = 16'h0090,
  parameter logic [ADDR_W-1:0] A_ID  = 7'h00,
  parameter logic [ADDR_W-1:0] A_VOL = 7'h02,
  parameter logic [ADDR_W-1:0] A_SER = 7'h74,
  parameter logic [ADDR_W-1:0] A_CFG = 7'h76
) (
  input  logic [ADDR_W-1:0] addr,
  input  mvol_t             vol,
  input  logic [WORD_W-1:0] ser,
  input  logic              split,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word = '0;
    unique case (addr)
      A_ID:    word = ID_VALUE;
      A_VOL:   word = mvol_word(vol);
      A_SER:   word = ser;
      A_CFG:   word = {{(WORD_W-1){1'b0}}, split};
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/codec_mix_regs.sv
module codec_mix_regs
  import cmx_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter logic [WORD_W-1:0] ID_VALUE    = 16'h0090,
  parameter logic [WORD_W-1:0] SER_DEFAULT = 16'h0000,
  parameter logic [ADDR_W-1:0] A_ID  = 7'h00,
  parameter logic [ADDR_W-1:0] A_VOL = 7'h02,
  parameter logic [ADDR_W-1:0] A_SER = 7'h74,
  parameter logic [ADDR_W-1:0] A_CFG = 7'h76
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic [4:0]        att_left,
  output logic [4:0]        att_right,
  output logic              mute_left,
  output logic              mute_right
);
  localparam int unsigned CH_LSB [NCH] = '{MV_LEFT_LSB, MV_RIGHT_LSB};

  mvol_t             vol_q;
  logic              split_q;
  logic [WORD_W-1:0] ser_q;
  logic [WORD_W-1:0] rd_word;
  logic [ATT_W-1:0]  att_w [NCH];

  logic wr_id, wr_vol, wr_ser, wr_cfg;
  always_comb begin
    wr_id  = wr_en && (addr == A_ID);
    wr_vol = wr_en && (addr == A_VOL);
    wr_ser = wr_en && (addr == A_SER);
    wr_cfg = wr_en && (addr == A_CFG);
  end

  // one saturating field decoder per channel
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cmx_vol_field #(.ATT_W(ATT_W)) u_field (
      .raw (wr_data[CH_LSB[c] +: ATT_W+1]),
      .att (att_w[c])
    );
  end

  // volume and configuration: cleared by reset or by a write to the ID word
  always_ff @(posedge clk) begin
    if (rst || wr_id) begin
      vol_q   <= MVOL_DEFAULT;
      split_q <= 1'b0;
    end else if (wr_vol) begin
      vol_q.mute_all <= wr_data[MV_MUTE_ALL];
      vol_q.left     <= att_w[0];
      vol_q.right    <= att_w[1];
      vol_q.mute_r   <= split_q & wr_data[MV_MUTE_R];
    end else if (wr_cfg) begin
      split_q <= wr_data[0];
      if (!wr_data[0]) vol_q.mute_r <= 1'b0;
    end
  end

  // serial setup word survives the software reset
  always_ff @(posedge clk) begin
    if (rst)         ser_q <= SER_DEFAULT;
    else if (wr_ser) ser_q <= wr_data;
  end

  cmx_read_mux #(
    .ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE),
    .A_ID(A_ID), .A_VOL(A_VOL), .A_SER(A_SER), .A_CFG(A_CFG)
  ) u_rmux (
    .addr  (addr),
    .vol   (vol_q),
    .ser   (ser_q),
    .split (split_q),
    .word  (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end

  cmx_mute_route u_mute (
    .split    (split_q),
    .mute_all (vol_q.mute_all),
    .mute_r   (vol_q.mute_r),
    .mute_l_o (mute_left),
    .mute_r_o (mute_right)
  );

  assign att_left  = vol_q.left;
  assign att_right = vol_q.right;
endmodule

// File: rtl/cmx_regs_chk.sv
module cmx_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        rd_en,
  input logic [6:0]  addr,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic [4:0]  att_left,
  input logic        mute_left,
  input logic        mute_right,
  input logic        split_q,
  input logic        rm_q,
  input logic [15:0] ser_q
);
  a_r3_id_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 7'h00) |=> rd_data == 16'h0090);

  a_r2_soft_reset: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 7'h00) |=> (!split_q && mute_left && mute_right && att_left == 5'd0));

  a_r4_ser_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 7'h00) |=> $stable(ser_q));

  a_r6_left_saturate: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 7'h02 && wr_data[13]) |=> att_left == 5'h1F);

  a_r7_rm_needs_split: assert property (@(posedge clk) disable iff (rst)
    !split_q |-> !rm_q);

  a_r8_shared_mute: assert property (@(posedge clk) disable iff (rst)
    !split_q |-> (mute_left == mute_right));

  a_r10_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != 7'h00 && addr != 7'h02 && addr != 7'h74 && addr != 7'h76)
      |=> rd_data == 16'h0000);

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !$past(rst)) |=> $stable(rd_data));
endmodule

bind codec_mix_regs cmx_regs_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .att_left(att_left),
  .mute_left(mute_left), .mute_right(mute_right),
  .split_q(split_q), .rm_q(vol_q.mute_r), .ser_q(ser_q)
);

// File: tb/tb_codec_mix_regs.sv
module tb_codec_mix_regs;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [6:0]  addr;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [4:0]  att_left, att_right;
  logic        mute_left, mute_right;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_mix_regs dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .att_left(att_left),
    .att_right(att_right), .mute_left(mute_left), .mute_right(mute_right)
  );

  // behavioural reference state
  int m_mm, m_lv, m_rm, m_rv, m_split, m_ser, m_rd;

  function automatic int ref_read(int a);
    case (a)
      'h00: return 'h0090;
      'h02: return (m_mm << 15) | (m_lv << 8) | (m_rm << 7) | m_rv;
      'h74: return m_ser;
      'h76: return m_split;
      default: return 0;
    endcase
  endfunction

  task automatic ref_defaults(bit full);
    m_mm = 1; m_lv = 0; m_rm = 0; m_rv = 0; m_split = 0;
    if (full) begin m_ser = 0; m_rd = 0; end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int ml, mr;
    vectors++;
    ml = m_mm;
    mr = m_split ? m_rm : m_mm;
    chk(tag, "rd_data", int'(rd_data), m_rd);
    chk(tag, "att_left", int'(att_left), m_lv);
    chk(tag, "att_right", int'(att_right), m_rv);
    chk(tag, "mute_left", int'(mute_left), ml);
    chk(tag, "mute_right", int'(mute_right), mr);
  endtask

  // called at a falling edge; applies one cycle and checks at the next falling edge
  task automatic step(bit w, bit r, int a, int d, string tag);
    rst = 0; wr_en = w; rd_en = r; addr = 7'(a); wr_data = 16'(d);
    if (r) m_rd = ref_read(a);
    if (w) begin
      case (a)
        'h00: ref_defaults(0);
        'h02: begin
          m_mm = (d >> 15) & 1;
          m_lv = ((d >> 13) & 1) ? 31 : ((d >> 8) & 31);
          m_rv = ((d >> 5) & 1) ? 31 : (d & 31);
          m_rm = m_split ? ((d >> 7) & 1) : 0;
        end
        'h74: m_ser = d & 'hFFFF;
        'h76: begin
          m_split = d & 1;
          if (m_split == 0) m_rm = 0;
        end
        default: ;
      endcase
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1; wr_en = 0; rd_en = 0; addr = '0; wr_data = '0;
    ref_defaults(1);
    @(negedge clk);
    @(negedge clk);
    compare("R1");
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 read back of defaults
    step(0, 1, 'h02, 0, "R1");
    step(0, 1, 'h76, 0, "R1");
    step(0, 1, 'h74, 0, "R1");
    // R3 ID read, then write to it, still the same ID
    step(0, 1, 'h00, 0, "R3");
    step(1, 0, 'h00, 'hFFFF, "R3");
    step(0, 1, 'h00, 0, "R3");
    // R5 R12 layout with reserved bits set
    step(1, 0, 'h02, 'h4A53, "R5");
    step(0, 1, 'h02, 0, "R5");
    step(1, 0, 'h02, 'h0A11, "R12");
    step(0, 1, 'h02, 0, "R12");
    // R6 overflow on each side
    step(1, 0, 'h02, 'h2005, "R6");
    step(0, 1, 'h02, 0, "R6");
    step(1, 0, 'h02, 'h0327, "R6");
    step(0, 1, 'h02, 0, "R6");
    step(1, 0, 'h02, 'hA0A0, "R6");
    step(0, 1, 'h02, 0, "R6");
    // R7 right mute dropped without split
    step(1, 0, 'h02, 'h0083, "R7");
    step(0, 1, 'h02, 0, "R7");
    step(1, 0, 'h76, 'h0001, "R9");
    step(0, 1, 'h02, 0, "R7");
    // R9 upper config bits read zero
    step(1, 0, 'h76, 'hFFFF, "R9");
    step(0, 1, 'h76, 0, "R9");
    // R8 routing with split on
    step(1, 0, 'h02, 'h0080, "R8");
    step(1, 0, 'h02, 'h8000, "R8");
    step(1, 0, 'h02, 'h8080, "R8");
    // R7 clearing split clears stored right mute
    step(1, 0, 'h76, 'h0000, "R7");
    step(0, 1, 'h02, 0, "R7");
    step(1, 0, 'h76, 'h0001, "R7");
    step(0, 1, 'h02, 0, "R7");
    // R8 routing with split off
    step(1, 0, 'h76, 'h0000, "R8");
    step(1, 0, 'h02, 'h0000, "R8");
    step(1, 0, 'h02, 'h8000, "R8");
    // R4 serial word and soft reset
    step(1, 0, 'h74, 'hBEEF, "R4");
    step(0, 1, 'h74, 0, "R4");
    step(1, 0, 'h76, 'h0001, "R2");
    step(1, 0, 'h02, 'h0C9E, "R2");
    step(1, 0, 'h00, 'h1234, "R2");
    step(0, 1, 'h02, 0, "R2");
    step(0, 1, 'h76, 0, "R2");
    step(0, 1, 'h74, 0, "R4");
    // R10 undefined addresses
    step(1, 0, 'h04, 'hFFFF, "R10");
    step(1, 0, 'h7E, 'h0001, "R10");
    step(0, 1, 'h04, 0, "R10");
    step(0, 1, 'h75, 0, "R10");
    step(0, 1, 'h02, 0, "R10");
    // R11 same-cycle read/write returns old data; hold when idle
    step(1, 1, 'h74, 'h1357, "R11");
    step(0, 0, 'h00, 0, "R11");
    step(1, 1, 'h02, 'h1F1F, "R11");
    step(0, 1, 'h02, 0, "R11");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int sel, a;
      sel = $urandom_range(0, 9);
      a = (sel < 3) ? 'h02 : (sel < 5) ? 'h76 : (sel < 7) ? 'h74 :
          (sel == 7) ? 'h00 : $urandom_range(0, 127);
      if (a == 'h00 && $urandom_range(0, 3) != 0) a = 'h02;
      step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a,
           $urandom_range(0, 65535), "R5");
    end
    // R1 reset mid-run
    step(1, 0, 'h74, 'h00FF, "R1");
    do_reset();
    step(0, 1, 'h74, 0, "R1");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule